// File: doc/BRIEF.md
# Key-Protected Control Register Bank

A bank of 32-bit control and status registers reached over a plain single-cycle bus: an address, an enable, a write flag, write data and registered read data. The first register is a guard word. The lower part of the control window can be changed only while the guard word holds a fixed 32-bit unlock value. The upper part of the window, and the guard word itself, can be written at any time. A handful of status offsets accept no writes. One offset is meant for writing only, but a read of it still returns its contents and is flagged.

At reset every register loads a computed default. Three registers instead capture external words: a revision word and two board strap words. Each access the bank refuses or flags produces a one-cycle error pulse with a two-bit cause code, so a bus monitor can log it. The lock state is also driven out as a status level.

Top module: `ctrl_regbank`

## Requirements
- R1: `bus_addr` is a byte address. The register index is `bus_addr >> 2`, and the two low address bits are ignored. An access happens on a rising clock edge with `bus_en` high; `bus_we` high makes it a write, low makes it a read.
- R2: `unlocked` is high exactly while register 0 holds 0x1688A8A8. Register 0 is always writable. A write of any other value to it drops `unlocked` in the cycle after the write.
- R3: While locked, writes to indices 1 through 64 (byte offsets 0x04 to 0x100) leave the register unchanged and raise cause 1 (locked).
- R4: Indices 65 and above (offset 0x104 upward) inside the bank accept writes whether locked or not, with no error.
- R5: Indices 5, 20 to 27, 30, 31, 56 and 57 (offsets 0x14, 0x50 to 0x6C, 0x78, 0x7C, 0xE0, 0xE4) are read-only. While unlocked, a write to one of them is dropped with cause 2 (read-only). While locked, such a write reports cause 1, because the lock check comes first.
- R6: An index at or above `NUM_REGS` (106 by default) reads as zero. A write to it is dropped. Both raise cause 0 (range).
- R7: A read of index 48 (offset 0xC0) returns the stored value and raises cause 3 (write-only read).
- R8: `bus_rdata` updates on the clock edge of a read and holds its value until the next read. `err_pulse` is high for exactly the one cycle after a refused or flagged access, and `err_cause` is 0 whenever `err_pulse` is low.
- R9: Reset defaults by index (all others zero): 1=FFCFFEDC, 2=F3F40000, 3=19FC3E8B, 7=00026108, 8=00030291, 9=00000291, 11=00000010, 12=20001A03, 13=20001A03, 14=04000030, 15=00000001, 16=000000C0, 19=00000023, 29=0000000E, 33=0000F000, 34=01000000, 35=000000FF, 36=0000A000, 39=003FFFF3, 41=FFFF0000, 42=000FFFFF, 56=000000FF, 57=000000FF, 65=80000000, 68=1E600000, 69=C0000000, 88=00001903, 96=0000007B, 105=00002402.
- R10: At reset, index 31 loads `rev_word`, index 28 loads `strap_a` and index 52 loads `strap_b`. Later changes on those inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rev_word | input | 32 | Revision word captured at reset |
| strap_a | input | 32 | First strap word captured at reset |
| strap_b | input | 32 | Second strap word captured at reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (17) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle flag for a refused or flagged access |
| err_cause | output | 2 | 0 range, 1 locked, 2 read-only, 3 write-only read |
| unlocked | output | 1 | Guard word holds the unlock value |

## Verification
The bench sweeps every index plus a few past the end three times: reading after reset, writing and reading back while locked, and writing and reading back while unlocked. Each time it compares data and error codes against its own model. The boundaries it targets are these:
- Index 64 against 65. An off-by-one lock window would either lock index 65 or leave index 64 open.
- The read-only holes written while locked. Checking the read-only attribute before the lock would report cause 2 instead of 1.
- A near-miss guard value and a relock. A partial key compare would leave the bank open.
- Index `NUM_REGS`. A wrong range compare would return stale data or take the write.
- Strap inputs changed after reset. If the straps were not captured, the strap registers would follow the inputs.

// File: rtl/ctrl_regbank_pkg.sv
package ctrl_regbank_pkg;

  localparam logic [31:0] UNLOCK_KEY = 32'h1688A8A8;

  localparam int unsigned LOCK_FIRST  = 1;
  localparam int unsigned LOCK_LAST   = 64;
  localparam int unsigned IDX_WRONLY  = 48;
  localparam int unsigned IDX_STRAP_A = 28;
  localparam int unsigned IDX_REV     = 31;
  localparam int unsigned IDX_STRAP_B = 52;

  typedef enum logic [1:0] {
    CAUSE_RANGE  = 2'd0,
    CAUSE_LOCKED = 2'd1,
    CAUSE_RDONLY = 2'd2,
    CAUSE_WRONLY = 2'd3
  } err_cause_e;

  function automatic logic is_rdonly(input int unsigned i);
    return (i == 5) || (i >= 20 && i <= 27) || (i == 30) || (i == 31) ||
           (i == 56) || (i == 57);
  endfunction

  function automatic logic in_lock_window(input int unsigned i);
    return (i >= LOCK_FIRST) && (i <= LOCK_LAST);
  endfunction

  function automatic logic [31:0] reset_value(input int unsigned i,
                                              input logic [31:0] rev,
                                              input logic [31:0] sa,
                                              input logic [31:0] sb);
    logic [31:0] v;
    case (i)
      1:   v = 32'hFFCFFEDC;
      2:   v = 32'hF3F40000;
      3:   v = 32'h19FC3E8B;
      7:   v = 32'h00026108;
      8:   v = 32'h00030291;
      9:   v = 32'h00000291;
      11:  v = 32'h00000010;
      12:  v = 32'h20001A03;
      13:  v = 32'h20001A03;
      14:  v = 32'h04000030;
      15:  v = 32'h00000001;
      16:  v = 32'h000000C0;
      19:  v = 32'h00000023;
      28:  v = sa;
      29:  v = 32'h0000000E;
      31:  v = rev;
      33:  v = 32'h0000F000;
      34:  v = 32'h01000000;
      35:  v = 32'h000000FF;
      36:  v = 32'h0000A000;
      39:  v = 32'h003FFFF3;
      41:  v = 32'hFFFF0000;
      42:  v = 32'h000FFFFF;
      52:  v = sb;
      56:  v = 32'h000000FF;
      57:  v = 32'h000000FF;
      65:  v = 32'h80000000;
      68:  v = 32'h1E600000;
      69:  v = 32'hC0000000;
      88:  v = 32'h00001903;
      96:  v = 32'h0000007B;
      105: v = 32'h00002402;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ctrl_regbank_decode.sv
module ctrl_regbank_decode
  import ctrl_regbank_pkg::*;
#(
  parameter int NUM_REGS = 106,
  parameter int IDX_W    = 15
) (
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] idx,
  input  logic             unlocked,
  output logic             wr_commit,
  output logic             rd_access,
  output logic             in_range,
  output logic             err_set,
  output logic [1:0]       err_code
);

  logic locked_hit;
  logic rdonly_hit;
  logic wronly_hit;

  always_comb begin
    in_range   = (32'(idx) < 32'(NUM_REGS));
    locked_hit = !unlocked && in_lock_window(32'(idx));
    rdonly_hit = is_rdonly(32'(idx));
    wronly_hit = (32'(idx) == IDX_WRONLY);

    wr_commit = 1'b0;
    rd_access = 1'b0;
    err_set   = 1'b0;
    err_code  = CAUSE_RANGE;

    if (bus_en) begin
      if (!in_range) begin
        err_set  = 1'b1;
        err_code = CAUSE_RANGE;
        rd_access = !bus_we;
      end else if (bus_we) begin
        if (locked_hit) begin
          err_set  = 1'b1;
          err_code = CAUSE_LOCKED;
        end else if (rdonly_hit) begin
          err_set  = 1'b1;
          err_code = CAUSE_RDONLY;
        end else begin
          wr_commit = 1'b1;
        end
      end else begin
        rd_access = 1'b1;
        if (wronly_hit) begin
          err_set  = 1'b1;
          err_code = CAUSE_WRONLY;
        end
      end
    end
  end

endmodule

// File: rtl/ctrl_regbank_store.sv
module ctrl_regbank_store
  import ctrl_regbank_pkg::*;
#(
  parameter int NUM_REGS = 106,
  parameter int IDX_W    = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_commit,
  input  logic [IDX_W-1:0]           idx,
  input  logic [31:0]                wdata,
  input  logic [31:0]                rev_word,
  input  logic [31:0]                strap_a,
  input  logic [31:0]                strap_b,
  output logic [NUM_REGS-1:0][31:0]  regs_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic        hit;
    logic [31:0] d;

    always_comb begin
      hit = wr_commit && (idx == IDX_W'(g));
      d   = hit ? wdata : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= reset_value(g, rev_word, strap_a, strap_b);
      end else if (hit) begin
        regs_q[g] <= d;
      end
    end
  end

endmodule

// File: rtl/ctrl_regbank_rdport.sv
module ctrl_regbank_rdport #(
  parameter int NUM_REGS = 106,
  parameter int IDX_W    = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_access,
  input  logic                      in_range,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_REGS-1:0][31:0] regs_q,
  input  logic                      err_set,
  input  logic [1:0]                err_code,
  output logic [31:0]               rdata,
  output logic                      err_pulse,
  output logic [1:0]                err_cause
);

  logic [31:0] sel;
  logic [31:0] rdata_d;
  logic [1:0]  cause_d;

  always_comb begin
    sel = 32'h0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) sel = regs_q[i];
    end
    rdata_d = in_range ? sel : 32'h0;
    cause_d = err_set ? err_code : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 32'h0;
    end else if (rd_access) begin
      rdata <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_cause <= 2'd0;
    end else begin
      err_pulse <= err_set;
      err_cause <= cause_d;
    end
  end

endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import ctrl_regbank_pkg::*;
#(
  parameter int NUM_REGS = 106,
  parameter int ADDR_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       rev_word,
  input  logic [31:0]       strap_a,
  input  logic [31:0]       strap_b,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              err_pulse,
  output logic [1:0]        err_cause,
  output logic              unlocked
);

  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]                rst_sync;
  logic                      rst_n_i;
  logic [IDX_W-1:0]          idx;
  logic                      wr_commit;
  logic                      rd_access;
  logic                      in_range;
  logic                      err_set;
  logic [1:0]                err_code;
  logic [NUM_REGS-1:0][31:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    rst_n_i  = rst_sync[1];
    idx      = bus_addr[ADDR_W-1:2];
    unlocked = (regs_q[0] == UNLOCK_KEY);
  end

  ctrl_regbank_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_decode (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .idx       (idx),
    .unlocked  (unlocked),
    .wr_commit (wr_commit),
    .rd_access (rd_access),
    .in_range  (in_range),
    .err_set   (err_set),
    .err_code  (err_code)
  );

  ctrl_regbank_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_commit (wr_commit),
    .idx       (idx),
    .wdata     (bus_wdata),
    .rev_word  (rev_word),
    .strap_a   (strap_a),
    .strap_b   (strap_b),
    .regs_q    (regs_q)
  );

  ctrl_regbank_rdport #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rdport (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .rd_access (rd_access),
    .in_range  (in_range),
    .idx       (idx),
    .regs_q    (regs_q),
    .err_set   (err_set),
    .err_code  (err_code),
    .rdata     (bus_rdata),
    .err_pulse (err_pulse),
    .err_cause (err_cause)
  );

endmodule

// File: rtl/ctrl_regbank_chk.sv
module ctrl_regbank_chk
  import ctrl_regbank_pkg::*;
#(
  parameter int NUM_REGS = 106,
  parameter int ADDR_W   = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              err_pulse,
  input logic [1:0]        err_cause,
  input logic              unlocked
);

  logic [31:0] ci;
  logic        c_in;

  always_comb begin
    ci   = 32'(bus_addr[ADDR_W-1:2]);
    c_in = ci < 32'(NUM_REGS);
  end

  assert_range_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !c_in |=> err_pulse && err_cause == 2'd0);

  assert_range_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we && !c_in |=> bus_rdata == 32'h0);

  assert_locked_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && !unlocked && ci >= 1 && ci <= 64 |=> err_pulse && err_cause == 2'd1);

  assert_key_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && ci == 0 && bus_wdata == 32'h1688A8A8 |=> unlocked);

  assert_key_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && ci == 0 && bus_wdata != 32'h1688A8A8 |=> !unlocked);

  assert_upper_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && c_in && ci >= 65 |=> !err_pulse);

  assert_wronly_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we && ci == 48 |=> err_pulse && err_cause == 2'd3);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !err_pulse && err_cause == 2'd0);

endmodule

bind ctrl_regbank ctrl_regbank_chk #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .err_pulse (err_pulse),
  .err_cause (err_cause),
  .unlocked  (unlocked)
);

// File: tb/ctrl_regbank_test.sv
`timescale 1ns/1ps
module ctrl_regbank_test;

  localparam int N  = 106;
  localparam int AW = 17;
  localparam logic [31:0] KEY = 32'h1688A8A8;
  localparam logic [31:0] REV = 32'hA5A50001;
  localparam logic [31:0] SA  = 32'h11112222;
  localparam logic [31:0] SB  = 32'h33334444;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   rev_word, strap_a, strap_b;
  logic          bus_en, bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          err_pulse;
  logic [1:0]    err_cause;
  logic          unlocked;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [N];

  always #2 clk = ~clk;

  ctrl_regbank #(.NUM_REGS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rev_word(rev_word), .strap_a(strap_a),
    .strap_b(strap_b), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_pulse(err_pulse),
    .err_cause(err_cause), .unlocked(unlocked)
  );

  function automatic logic [31:0] dflt(input int i);
    case (i)
      1: return 32'hFFCFFEDC;   2: return 32'hF3F40000;   3: return 32'h19FC3E8B;
      7: return 32'h00026108;   8: return 32'h00030291;   9: return 32'h00000291;
      11: return 32'h00000010;  12: return 32'h20001A03;  13: return 32'h20001A03;
      14: return 32'h04000030;  15: return 32'h00000001;  16: return 32'h000000C0;
      19: return 32'h00000023;  28: return SA;            29: return 32'h0000000E;
      31: return REV;           33: return 32'h0000F000;  34: return 32'h01000000;
      35: return 32'h000000FF;  36: return 32'h0000A000;  39: return 32'h003FFFF3;
      41: return 32'hFFFF0000;  42: return 32'h000FFFFF;  52: return SB;
      56: return 32'h000000FF;  57: return 32'h000000FF;  65: return 32'h80000000;
      68: return 32'h1E600000;  69: return 32'hC0000000;  88: return 32'h00001903;
      96: return 32'h0000007B;  105: return 32'h00002402;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic ro(input int i);
    return i == 5 || (i >= 20 && i <= 27) || i == 30 || i == 31 || i == 56 || i == 57;
  endfunction

  // {pulse, cause}
  function automatic logic [2:0] exp_err(input logic we, input int i, input logic unl);
    if (i >= N) return 3'b100;
    if (we) begin
      if (!unl && i >= 1 && i <= 64) return 3'b101;
      if (ro(i)) return 3'b110;
      return 3'b000;
    end
    if (i == 48) return 3'b111;
    return 3'b000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input int i, input logic [31:0] d, input logic [1:0] low);
    @(negedge clk);
    bus_en    = 1'b1;
    bus_we    = we;
    bus_addr  = AW'(i * 4) | AW'(low);
    bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0;
    bus_we = 1'b0;
  endtask

  function automatic string rtag(input int phase, input int i);
    if (i >= N) return "R6";
    if (i == 48) return "R7";
    if (phase == 0) return (i == 28 || i == 31 || i == 52) ? "R10" : "R9";
    if (phase == 1) return (i >= 65) ? "R4" : "R3";
    return ro(i) ? "R5" : "R2";
  endfunction

  task automatic read_sweep(input int phase);
    for (int i = 0; i < N + 3; i++) begin
      acc(1'b0, i, 32'h0, 2'b00);
      check(rtag(phase, i), bus_rdata, (i < N) ? model[i] : 32'h0);
      check({rtag(phase, i), " err"}, {29'h0, err_pulse, err_cause},
            {29'h0, exp_err(1'b0, i, model[0] == KEY)});
    end
  endtask

  task automatic write_sweep(input int phase, input logic [31:0] base);
    for (int i = 1; i < N + 2; i++) begin
      logic [2:0]  e;
      logic [31:0] d;
      d = base ^ (32'(i) * 32'h01010101);
      e = exp_err(1'b1, i, model[0] == KEY);
      acc(1'b1, i, d, 2'b00);
      if (i < N && e == 3'b000) model[i] = d;
      check({(phase == 1) ? ((i >= 65) ? "R4" : "R3") : (ro(i) ? "R5" : "R2"), " werr"},
            {29'h0, err_pulse, err_cause}, {29'h0, e});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rev_word = REV; strap_a = SA; strap_b = SB;
    for (int i = 0; i < N; i++) model[i] = dflt(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rev_word = 32'hDEADBEEF; strap_a = 32'h0BADF00D; strap_b = 32'hFEEDFACE;
    @(negedge clk);

    check("R8 reset rdata", bus_rdata, 32'h0);
    check("R8 reset err", {31'h0, err_pulse}, 32'h0);
    check("R2 reset lock", {31'h0, unlocked}, 32'h0);

    read_sweep(0);

    // R8: read data holds with no access, no error pulse
    acc(1'b0, 16, 32'h0, 2'b00);
    @(negedge clk);
    check("R8 hold", bus_rdata, model[16]);
    check("R8 quiet", {30'h0, err_pulse, err_cause}, 32'h0);

    write_sweep(1, 32'h5A000000);
    read_sweep(1);

    acc(1'b1, 0, KEY ^ 32'h1, 2'b00);
    model[0] = KEY ^ 32'h1;
    check("R2 near miss", {31'h0, unlocked}, 32'h0);
    acc(1'b1, 0, KEY, 2'b00);
    model[0] = KEY;
    check("R2 open", {31'h0, unlocked}, 32'h1);

    write_sweep(2, 32'hC3000000);
    read_sweep(2);

    // R1: low address bits ignored
    acc(1'b1, 70, 32'h76543210, 2'b11);
    model[70] = 32'h76543210;
    acc(1'b0, 70, 32'h0, 2'b01);
    check("R1 low bits", bus_rdata, 32'h76543210);

    // R2: relock and confirm a locked write is dropped
    acc(1'b1, 0, 32'h0, 2'b00);
    model[0] = 32'h0;
    check("R2 relock", {31'h0, unlocked}, 32'h0);
    acc(1'b1, 2, 32'h12345678, 2'b00);
    check("R3 relock werr", {30'h0, err_pulse, err_cause}, 32'h5);
    acc(1'b0, 2, 32'h0, 2'b00);
    check("R3 relock data", bus_rdata, model[2]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule